// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A small synthesizable model of a single-port synchronous SRAM with registered inputs and a registered read path. Each word holds `BYTES` bytes of `BYTE_W` bits (default four 9-bit bytes, 36 bits) and the depth is a parameter between 16 and 64 words. The common data bus is split into a data-in port, a data-out port and a drive-enable output. A bus wrapper would combine them into a tri-state pin.

An access starts on a clock edge at which one of two address strobes is low: the processor strobe (`proc_stb_n`) or the controller strobe (`ctrl_stb_n`). The chip must be selected by all three chip selects (`chip_sel_n`). An access loads the address into a base register and clears a 2-bit wraparound burst counter. On each later cycle with no strobe, the device continues the access at the current burst address. If the advance input is low, the counter steps first. The cycle is a write if global write or byte-write enable is low. Otherwise it is a read.

A write started by the processor strobe takes two edges: the strobe edge always acts as a read lookup, and the write happens on the following edge. A write started by the controller strobe finishes on its own edge. The drive-enable is forced low on deselect, on the first cycle after the device becomes selected, during write cycles, and whenever output enable is high.

Top module: `sync_burst_ram`

## Requirements
- R1: After reset the drive-enable is low and every word of the array reads back as zero.
- R2: A read sampled on one edge presents `mem[address]` on `rd_data` after that edge. The drive-enable is high once the outputs are allowed and `out_en_n` is low.
- R3: When `chip_sel_n[0]` is high, a low `proc_stb_n` is ignored. With `ctrl_stb_n` high, that edge acts as a continuation cycle: the base address is not reloaded and the current address is read again.
- R4: On the first cycle after an edge that moves the device from deselected to selected, the drive-enable is low. On the next read edge it follows `out_en_n`.
- R5: An edge at which a strobe is taken while any chip select is inactive deselects the device. The drive-enable is low after that edge.
- R6: A processor-strobe edge ignores the write controls and performs a read. A write takes place on the next edge, without a strobe, using the write controls sampled there.
- R7: A controller-strobe edge with `proc_stb_n` high and a write control low writes on that same edge. If `proc_stb_n` is also low and the processor strobe is taken, no write happens on that edge.
- R8: Byte i is bits [9i+8:9i] and is selected by `byte_sel_n[i]` low when `byte_wr_n` is low. `glob_wr_n` low writes all bytes regardless of the byte inputs. Unselected bytes keep their contents.
- R9: While a write control is low and the processor strobe is not taken, the drive-enable is low whatever `out_en_n` is.
- R10: `out_en_n` high forces the drive-enable low without waiting for a clock.
- R11: A continuation cycle with `advance_n` low steps the burst counter before the access. In the default linear order, the low two address bits go start, start+1, … modulo 4. The upper address bits stay fixed.
- R12: `advance_n` is ignored on a strobe edge: the access uses the presented address and the burst counter restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears state and array |
| addr | input | ADDR_W | Word address sampled on a strobe edge |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| chip_sel_n | input | 3 | Three synchronous chip selects, active low |
| advance_n | input | 1 | Burst advance, active low |
| glob_wr_n | input | 1 | Global write, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| byte_sel_n | input | BYTES | Per-byte write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wr_data | input | BYTES*BYTE_W | Data-in side of the bus |
| rd_data | output | BYTES*BYTE_W | Registered read data |
| rd_drive | output | 1 | Drive-enable for the bus |

## Verification
The bench targets the cycle on which a processor-strobe write lands. A design that wrote on the strobe edge would overwrite the word with the data held there, and a design that skipped the second edge would leave it unchanged. It checks that the global write ignores a byte mask of all ones. It checks that a masked write leaves the other bytes intact, and that a low processor strobe with the first select high neither reloads the address nor deselects. It walks a burst through the wrap of the 4-word group, where a plain incrementer would step into the next group. It also watches the drive-enable on the reselect cycle, on the second write cycle, and when output enable rises, where a design that drove too early would contend with incoming data.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } sbr_op_e;

   localparam int BURST_W = 2;
endpackage

// File: rtl/sbr_burst_ctr.sv
module sbr_burst_ctr #(
   parameter int ADDR_W      = 5,
   parameter bit INTERLEAVED = 1'b0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             load,
   input  logic                             step,
   input  logic [ADDR_W-1:0]                addr_in,
   output logic [ADDR_W-1:0]                addr_use,
   output logic [ADDR_W-1:0]                base_q,
   output logic [sbr_pkg::BURST_W-1:0]      cnt_q
);
   localparam int BW = sbr_pkg::BURST_W;

   logic [ADDR_W-1:0] base_use;
   logic [BW-1:0]     cnt_use;
   logic [BW-1:0]     lo_use;

   always_comb begin
      base_use = load ? addr_in : base_q;
      if (load)      cnt_use = '0;
      else if (step) cnt_use = cnt_q + BW'(1);
      else           cnt_use = cnt_q;
   end

   generate
      if (INTERLEAVED) begin : g_xor_order
         assign lo_use = base_use[BW-1:0] ^ cnt_use;
      end else begin : g_lin_order
         assign lo_use = base_use[BW-1:0] + cnt_use;
      end
   endgenerate

   assign addr_use = {base_use[ADDR_W-1:BW], lo_use};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (load || step) begin
         base_q <= base_use;
         cnt_q  <= cnt_use;
      end
   end
endmodule

// File: rtl/sbr_array.sv
module sbr_array #(
   parameter int WORDS  = 32,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 9,
   localparam int ADDR_W = $clog2(WORDS),
   localparam int DATA_W = BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTES-1:0]  bmask,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata_q
);
   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
         rdata_q <= '0;
      end else begin
         if (we) begin
            for (int b = 0; b < BYTES; b++) begin
               if (bmask[b]) mem[addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
         end
         if (re) rdata_q <= mem[addr];
      end
   end
endmodule

// File: rtl/sbr_out_ctl.sv
module sbr_out_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic desel,
   input  logic cont,
   input  logic is_read,
   input  logic wr_detect,
   input  logic oe_n,
   output logic active_q,
   output logic drive
);
   logic out_ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         out_ok_q <= 1'b0;
      end else if (desel) begin
         active_q <= 1'b0;
         out_ok_q <= 1'b0;
      end else if (start || cont) begin
         active_q <= 1'b1;
         out_ok_q <= active_q && is_read;
      end
   end

   assign drive = out_ok_q && !oe_n && !wr_detect;
endmodule

// File: rtl/sync_burst_ram.sv
module sync_burst_ram #(
   parameter int WORDS       = 32,
   parameter int BYTES       = 4,
   parameter int BYTE_W      = 9,
   parameter bit INTERLEAVED = 1'b0,
   localparam int ADDR_W     = $clog2(WORDS),
   localparam int DATA_W     = BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              proc_stb_n,
   input  logic              ctrl_stb_n,
   input  logic [2:0]        chip_sel_n,
   input  logic              advance_n,
   input  logic              glob_wr_n,
   input  logic              byte_wr_n,
   input  logic [BYTES-1:0]  byte_sel_n,
   input  logic              out_en_n,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_drive
);
   import sbr_pkg::*;

   generate
      if (WORDS < 16 || WORDS > 64 || (1 << ADDR_W) != WORDS) begin : g_bad_words
         $error("sync_burst_ram: WORDS must be a power of two in 16..64");
      end
      if (BYTES < 1 || BYTE_W < 1) begin : g_bad_bytes
         $error("sync_burst_ram: BYTES and BYTE_W must be positive");
      end
   endgenerate

   logic              ps_take, cs_take, strobe, sel_all, wr_ctl;
   logic              start, desel, cont, wr_detect, active;
   logic [BYTES-1:0]  bmask;
   logic [ADDR_W-1:0] addr_use, burst_base;
   logic [BURST_W-1:0] burst_cnt;
   sbr_op_e           op;

   always_comb begin
      ps_take   = !proc_stb_n && !chip_sel_n[0];
      cs_take   = !ctrl_stb_n && !ps_take;
      strobe    = ps_take || cs_take;
      sel_all   = (chip_sel_n == 3'b000);
      wr_ctl    = !glob_wr_n || !byte_wr_n;
      start     = strobe && sel_all;
      desel     = strobe && !sel_all;
      cont      = !strobe && active;
      wr_detect = wr_ctl && !ps_take;
      if (!glob_wr_n)      bmask = '1;
      else if (!byte_wr_n) bmask = ~byte_sel_n;
      else                 bmask = '0;
      if (start)     op = (cs_take && wr_ctl) ? OP_WRITE : OP_READ;
      else if (cont) op = wr_ctl ? OP_WRITE : OP_READ;
      else           op = OP_IDLE;
   end

   sbr_burst_ctr #(.ADDR_W(ADDR_W), .INTERLEAVED(INTERLEAVED)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .step     (cont && !advance_n),
      .addr_in  (addr),
      .addr_use (addr_use),
      .base_q   (burst_base),
      .cnt_q    (burst_cnt)
   );

   sbr_array #(.WORDS(WORDS), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (op == OP_WRITE),
      .re      (op == OP_READ),
      .addr    (addr_use),
      .bmask   (bmask),
      .wdata   (wr_data),
      .rdata_q (rd_data)
   );

   sbr_out_ctl u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .desel     (desel),
      .cont      (cont),
      .is_read   (op == OP_READ),
      .wr_detect (wr_detect),
      .oe_n      (out_en_n),
      .active_q  (active),
      .drive     (rd_drive)
   );
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              proc_stb_n,
   input logic              ctrl_stb_n,
   input logic [2:0]        chip_sel_n,
   input logic              glob_wr_n,
   input logic              out_en_n,
   input logic              rd_drive,
   input logic              active,
   input logic [ADDR_W-1:0] burst_base,
   input logic [1:0]        burst_cnt
);
   AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !rd_drive); // R10
   AST_DESELECT_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
      (((!proc_stb_n && !chip_sel_n[0]) || !ctrl_stb_n) && chip_sel_n != 3'b000) |=> !rd_drive); // R5
   AST_FIRST_CYCLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> !rd_drive); // R4
   AST_WRITE_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_wr_n && (proc_stb_n || chip_sel_n[0])) |-> !rd_drive); // R9
   AST_PROC_STB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_stb_n && chip_sel_n[0] && ctrl_stb_n) |=> $stable(burst_base)); // R3
   AST_ADVANCE_IGNORED_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (((!proc_stb_n && !chip_sel_n[0]) || !ctrl_stb_n) && chip_sel_n == 3'b000) |=> burst_cnt == 2'd0); // R12
endmodule

bind sync_burst_ram sbr_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .proc_stb_n (proc_stb_n),
   .ctrl_stb_n (ctrl_stb_n),
   .chip_sel_n (chip_sel_n),
   .glob_wr_n  (glob_wr_n),
   .out_en_n   (out_en_n),
   .rd_drive   (rd_drive),
   .active     (active),
   .burst_base (burst_base),
   .burst_cnt  (burst_cnt)
);

// File: tb/sync_burst_ram_bench.sv
module sync_burst_ram_bench;
   localparam int WORDS  = 32;
   localparam int BYTES  = 4;
   localparam int BYTE_W = 9;
   localparam int AW     = $clog2(WORDS);
   localparam int DW     = BYTES * BYTE_W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, advance_n = 1'b1;
   logic          glob_wr_n = 1'b1, byte_wr_n = 1'b1, out_en_n = 1'b0;
   logic [2:0]    chip_sel_n = 3'b111;
   logic [BYTES-1:0] byte_sel_n = '1;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          rd_drive;

   logic [DW-1:0] ref_mem [WORDS];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   sync_burst_ram #(.WORDS(WORDS), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_sync_burst_ram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .proc_stb_n(proc_stb_n),
      .ctrl_stb_n(ctrl_stb_n), .chip_sel_n(chip_sel_n), .advance_n(advance_n),
      .glob_wr_n(glob_wr_n), .byte_wr_n(byte_wr_n), .byte_sel_n(byte_sel_n),
      .out_en_n(out_en_n), .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
   );

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic idle_inputs();
      proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; chip_sel_n = 3'b000; advance_n = 1'b1;
      glob_wr_n = 1'b1; byte_wr_n = 1'b1; byte_sel_n = '1; out_en_n = 1'b0;
   endtask

   function automatic logic [DW-1:0] pat(input int a);
      return DW'(36'h1_2345_6789) ^ DW'(a * 36'h0_0F0F_1357);
   endfunction

   function automatic logic [BYTES-1:0] exp_mask(input logic gwn, input logic bwen, input logic [BYTES-1:0] bsn);
      if (!gwn) return '1;
      if (!bwen) return ~bsn;
      return '0;
   endfunction

   task automatic ref_write(input int a, input logic [DW-1:0] d, input logic [BYTES-1:0] m);
      for (int b = 0; b < BYTES; b++)
         if (m[b]) ref_mem[a][b*BYTE_W +: BYTE_W] = d[b*BYTE_W +: BYTE_W];
   endtask

   task automatic ctrl_write(input int a, input logic [DW-1:0] d, input logic gwn, input logic bwen, input logic [BYTES-1:0] bsn);
      idle_inputs();
      ctrl_stb_n = 1'b0; addr = AW'(a); wr_data = d;
      glob_wr_n = gwn; byte_wr_n = bwen; byte_sel_n = bsn;
      tick();
      ref_write(a, d, exp_mask(gwn, bwen, bsn));
      idle_inputs();
   endtask

   task automatic read_back(input int a, input string req);
      idle_inputs();
      ctrl_stb_n = 1'b0; addr = AW'(a);
      tick();
      idle_inputs();
      tick();
      check(rd_drive === 1'b1 && rd_data === ref_mem[a], req, rd_data, ref_mem[a]);
   endtask

   task automatic t_reset();
      check(rd_drive === 1'b0, "R1 drive low after reset", DW'(rd_drive), '0);
      idle_inputs();
      ctrl_stb_n = 1'b0; addr = AW'(5);
      tick();
      check(rd_drive === 1'b0, "R4 first cycle after select", DW'(rd_drive), '0);
      idle_inputs();
      tick();
      check(rd_drive === 1'b1 && rd_data === '0, "R1 array zero at reset", rd_data, '0);
   endtask

   task automatic t_ctrl_write();
      idle_inputs();
      glob_wr_n = 1'b0; #1;
      check(rd_drive === 1'b0, "R9 drive off while write control low", DW'(rd_drive), '0);
      ctrl_write(3, pat(3), 1'b0, 1'b1, '1);
      idle_inputs();
      proc_stb_n = 1'b0; addr = AW'(3);
      tick();
      check(rd_drive === 1'b1 && rd_data === ref_mem[3], "R7 R2 single-cycle write read back", rd_data, ref_mem[3]);
      idle_inputs();
   endtask

   task automatic t_proc_write();
      idle_inputs();
      proc_stb_n = 1'b0; addr = AW'(9); glob_wr_n = 1'b0; wr_data = pat(99);
      tick();
      check(rd_data === ref_mem[9], "R6 strobe edge ignores write", rd_data, ref_mem[9]);
      idle_inputs();
      byte_wr_n = 1'b0; byte_sel_n = 4'b1010; wr_data = pat(9);
      #1;
      check(rd_drive === 1'b0, "R9 drive off in second write cycle", DW'(rd_drive), '0);
      tick();
      ref_write(9, pat(9), 4'b0101);
      idle_inputs();
      read_back(9, "R6 R8 masked two-cycle write");
   endtask

   task automatic t_override();
      ctrl_write(9, pat(77), 1'b0, 1'b0, '1);
      read_back(9, "R8 global write overrides byte selects");
      ctrl_write(3, pat(55), 1'b1, 1'b0, 4'b0111);
      read_back(3, "R8 unselected bytes unchanged");
      ctrl_write(3, pat(66), 1'b1, 1'b1, 4'b0000);
      read_back(3, "R8 no write control no change");
   endtask

   task automatic t_both_strobes();
      idle_inputs();
      proc_stb_n = 1'b0; ctrl_stb_n = 1'b0; addr = AW'(3); glob_wr_n = 1'b0; wr_data = pat(123);
      tick();
      idle_inputs();
      read_back(3, "R7 no write when processor strobe also low");
   endtask

   task automatic t_ps_ignored();
      read_back(3, "R2 read before ignored strobe");
      proc_stb_n = 1'b0; chip_sel_n = 3'b001; addr = AW'(12);
      tick();
      check(rd_drive === 1'b1 && rd_data === ref_mem[3], "R3 ignored strobe keeps address", rd_data, ref_mem[3]);
      idle_inputs();
   endtask

   task automatic t_deselect();
      idle_inputs();
      ctrl_stb_n = 1'b0; chip_sel_n = 3'b010;
      tick();
      check(rd_drive === 1'b0, "R5 deselect tri-states", DW'(rd_drive), '0);
      idle_inputs();
      tick();
      check(rd_drive === 1'b0, "R5 stays off while deselected", DW'(rd_drive), '0);
      ctrl_stb_n = 1'b0; addr = AW'(9);
      tick();
      check(rd_drive === 1'b0, "R4 off on reselect cycle", DW'(rd_drive), '0);
      idle_inputs();
      tick();
      check(rd_drive === 1'b1 && rd_data === ref_mem[9], "R4 follows enable after first cycle", rd_data, ref_mem[9]);
      out_en_n = 1'b1; #1;
      check(rd_drive === 1'b0, "R10 enable high drops drive", DW'(rd_drive), '0);
      out_en_n = 1'b0; #1;
      check(rd_drive === 1'b1, "R10 enable low restores drive", DW'(rd_drive), 1);
   endtask

   task automatic t_burst();
      for (int a = 4; a < 8; a++) ctrl_write(a, pat(a + 40), 1'b0, 1'b1, '1);
      idle_inputs();
      ctrl_stb_n = 1'b0; addr = AW'(6); advance_n = 1'b0;
      tick();
      check(rd_data === ref_mem[6], "R12 advance ignored on strobe", rd_data, ref_mem[6]);
      idle_inputs();
      advance_n = 1'b0;
      for (int k = 1; k <= 4; k++) begin
         int e = 4 + ((2 + k) % 4);
         tick();
         check(rd_drive === 1'b1 && rd_data === ref_mem[e], "R11 linear burst with wrap", rd_data, ref_mem[e]);
      end
      idle_inputs();
   endtask

   initial begin
      for (int w = 0; w < WORDS; w++) ref_mem[w] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      t_reset();
      t_ctrl_write();
      t_proc_write();
      t_override();
      t_both_strobes();
      t_ps_ignored();
      t_deselect();
      t_burst();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule